// File: doc/BRIEF.md
# Oversampling Serial Receiver with Programmable Sample Points

This block receives asynchronous serial characters on a single data line. A one-cycle oversampling tick paces it. While idle it watches for a low level on the line, then counts ticks inside each bit period. At three programmable tick positions in each bit it captures the line, and a majority vote over those three samples decides the bit. The oversampling rate is 16, 8 or 3 ticks per bit. At 16x and 8x a two-bit adjust code moves the three sample points inside the bit, which lets the receiver tolerate skewed or distorted edges.

A character has a start bit, eight data bits and an optional parity bit of odd or even sense, then one stop bit. The data bits can be inverted on entry and received either most-significant or least-significant bit first. Finished characters go into a two-entry buffer together with their parity-error and frame-error marks. A character that arrives while the buffer is full is dropped. The loss is reported on an overflow output, either right away or when the reader reaches the point in the stream where the character was lost.

Top module: `uart_os_rx`

## Requirements
- R1: `rate_sel` selects the ticks per bit: codes 0 and 1 give 16, codes 2 and 3 give 8, and code 4 gives 3. The reserved codes 5, 6 and 7 behave like 16.
- R2: Tick position 1 is the tick on which the idle receiver first sees `rxd` low. At 16x, `adj_sel` values 0, 1, 2 and 3 place the three samples at positions 7-8-9, 9-10-11, 11-12-13 and 13-14-15.
- R3: At 8x, `adj_sel` values 0, 1, 2 and 3 place the three samples at positions 3-4-5, 4-5-6, 5-6-7 and 6-7-8.
- R4: At 3x, all three ticks of a bit are the samples and `adj_sel` is ignored. At every rate, a bit's value is the majority of its three samples, so one wrong sample does not change the bit.
- R5: A start bit is accepted only when its majority is 0. Otherwise the receiver goes back to idle and stores no character.
- R6: A character has eight data bits. With `lsb_first`=0 the first data bit received lands in `rx_data[7]`. With `lsb_first`=1 it lands in `rx_data[0]`.
- R7: With `rx_inv`=1 each data bit is inverted as it is received. Start, parity and stop bits are read unchanged, and parity is checked against the inverted data.
- R8: With `par_en`=1 a parity bit follows the data. With `par_odd`=0 it must equal the XOR of the eight received data bits. With `par_odd`=1 it must equal the complement of that XOR. A mismatch sets `rx_perr` for that character. With `par_en`=0, `rx_perr` is 0.
- R9: A stop bit whose majority is 0 sets `rx_ferr` for that character. The character is still stored.
- R10: The buffer holds two characters in arrival order. `rx_valid` is 1 while the buffer is not empty. `rx_data`, `rx_perr` and `rx_ferr` show the oldest character, and a `rd_ack` pulse while `rx_valid` is 1 removes it.
- R11: A character that completes while the buffer is full, with no removal in the same cycle, is discarded and the stored characters are kept.
- R12: With `imm_ovf`=1, `rx_ovf` rises in the cycle after a character is discarded and stays 1 until the next removal.
- R13: With `imm_ovf`=0, the discard marks the newest stored character. `rx_ovf` is 1 while that character is at the head of the buffer.
- R14: After reset, `rx_valid` and `rx_ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling tick, one cycle wide |
| rxd | input | 1 | Serial data line, idle high |
| rate_sel | input | 3 | Oversampling rate code |
| adj_sel | input | 2 | Sample point adjust code |
| rx_inv | input | 1 | Invert received data bits |
| lsb_first | input | 1 | 1: first data bit is bit 0 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| imm_ovf | input | 1 | 1: report overflow at once, 0: report it in stream order |
| rd_ack | input | 1 | Remove the head character |
| rx_data | output | 8 | Head character data |
| rx_valid | output | 1 | Buffer not empty |
| rx_perr | output | 1 | Parity error of head character |
| rx_ferr | output | 1 | Frame error of head character |
| rx_ovf | output | 1 | Overflow indication |

## Verification
The embedded properties assume three things about the inputs. `rxd` is already synchronous to `clk`. `os_tick` is a single-cycle pulse. The rate, adjust, invert, order and parity controls stay fixed while a character is in flight. The stimulus holds to this by changing the controls only in idle gaps before a start bit, by driving every input on the falling clock edge, and by raising the tick on every fourth cycle. Each data bit is shaped so that only the intended three sample positions carry the true level, which makes a wrong placement of the sample points visible in the received data.

// File: rtl/uos_pkg.sv
package uos_pkg;

    localparam int DBITS = 8;
    localparam int PW    = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } fr_state_e;

    typedef struct packed {
        logic [DBITS-1:0] data;
        logic             perr;
        logic             ferr;
        logic             ovf;
    } rx_char_t;

    // ticks per bit for a rate code; reserved codes fall back to 16
    function automatic logic [PW-1:0] os_len(input logic [2:0] rate);
        case (rate)
            3'd2, 3'd3: os_len = PW'(8);
            3'd4:       os_len = PW'(3);
            default:    os_len = PW'(16);
        endcase
    endfunction

    // first of the three sample positions in a bit
    function automatic logic [PW-1:0] first_pos(input logic [2:0] rate,
                                                input logic [1:0] adj);
        case (rate)
            3'd2, 3'd3: first_pos = PW'(3) + PW'(adj);
            3'd4:       first_pos = PW'(1);
            default:    first_pos = PW'(7) + PW'({adj, 1'b0});
        endcase
    endfunction

    function automatic logic maj3(input logic [2:0] s);
        maj3 = (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/uos_bitclk.sv
module uos_bitclk
    import uos_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic [2:0] rate,
    input  logic [1:0] adj,
    input  logic       busy,
    output logic       begin_o,
    output logic       bit_done_o,
    output logic       bit_val_o
);

    localparam int NS = 3;

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] cur;
    logic [PW-1:0] len;
    logic [PW-1:0] lo;
    logic [NS-1:0] smp_q;
    logic [NS-1:0] hit;
    logic [NS-1:0] eff;
    logic          active;

    assign cur     = cnt_q + PW'(1);
    assign len     = os_len(rate);
    assign lo      = first_pos(rate, adj);
    assign begin_o = tick & ~busy & ~rxd;
    assign active  = tick & (busy | ~rxd);

    generate
        for (genvar k = 0; k < NS; k++) begin : g_smp
            assign hit[k] = active & (cur == lo + PW'(k));
            // the sample taken on the deciding tick joins the vote directly
            assign eff[k] = hit[k] ? rxd : smp_q[k];
            always_ff @(posedge clk) begin
                if (rst)
                    smp_q[k] <= 1'b1;
                else if (hit[k])
                    smp_q[k] <= rxd;
            end
        end
    endgenerate

    assign bit_done_o = active & (cur == len);
    assign bit_val_o  = maj3(eff);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (active)
            cnt_q <= bit_done_o ? '0 : cur;
        else if (!busy)
            cnt_q <= '0;
    end

    // R2
    hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    // R1
    bit_end_chk: assert property (@(posedge clk) disable iff (rst)
        bit_done_o |=> (cnt_q == '0));

endmodule

// File: rtl/uos_framer.sv
module uos_framer
    import uos_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     begin_i,
    input  logic     bit_done,
    input  logic     bit_val,
    input  logic     rx_inv,
    input  logic     lsb_first,
    input  logic     par_en,
    input  logic     par_odd,
    output logic     busy,
    output logic     push_o,
    output rx_char_t char_o
);

    localparam int IW = $clog2(DBITS);

    fr_state_e        state_q;
    logic [IW-1:0]    idx_q;
    logic [DBITS-1:0] sh_q;
    logic             par_acc_q;
    logic             perr_q;
    logic             push_q;
    rx_char_t         char_q;
    logic             dbit;

    assign busy   = (state_q != ST_IDLE);
    assign dbit   = bit_val ^ rx_inv;
    assign push_o = push_q;
    assign char_o = char_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            sh_q      <= '0;
            par_acc_q <= 1'b0;
            perr_q    <= 1'b0;
            push_q    <= 1'b0;
            char_q    <= '0;
        end else begin
            push_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (begin_i)
                        state_q <= ST_START;
                end
                ST_START: begin
                    if (bit_done) begin
                        state_q   <= bit_val ? ST_IDLE : ST_DATA;
                        idx_q     <= '0;
                        par_acc_q <= 1'b0;
                        perr_q    <= 1'b0;
                    end
                end
                ST_DATA: begin
                    if (bit_done) begin
                        sh_q      <= lsb_first ? {dbit, sh_q[DBITS-1:1]}
                                               : {sh_q[DBITS-2:0], dbit};
                        par_acc_q <= par_acc_q ^ dbit;
                        idx_q     <= idx_q + IW'(1);
                        if (idx_q == IW'(DBITS - 1))
                            state_q <= par_en ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    if (bit_done) begin
                        perr_q  <= bit_val ^ par_acc_q ^ par_odd;
                        state_q <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (bit_done) begin
                        push_q      <= 1'b1;
                        char_q.data <= sh_q;
                        char_q.perr <= par_en & perr_q;
                        char_q.ferr <= ~bit_val;
                        char_q.ovf  <= 1'b0;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5
    false_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && bit_done && bit_val) |=> (state_q == ST_IDLE && !push_o));

    // R9
    push_idle_chk: assert property (@(posedge clk) disable iff (rst)
        push_o |-> (state_q == ST_IDLE));

endmodule

// File: rtl/uos_rxbuf.sv
module uos_rxbuf
    import uos_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rx_char_t char_i,
    input  logic     rd_ack,
    input  logic     imm_i,
    output rx_char_t head_o,
    output logic     valid_o,
    output logic     ovf_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_char_t      mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] last_ptr;
    logic [CW-1:0] cnt;
    logic          full;
    logic          pop;
    logic          push_ok;
    logic          drop;
    logic          imm_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        nxt = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full     = (cnt == CW'(DEPTH));
    assign valid_o  = (cnt != '0);
    assign pop      = rd_ack & valid_o;
    assign push_ok  = push & (~full | pop);
    assign drop     = push & full & ~pop;
    assign last_ptr = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - AW'(1);
    assign head_o   = mem[rd_ptr];
    assign ovf_o    = imm_q | (valid_o & mem[rd_ptr].ovf);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            imm_q  <= 1'b0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr]     <= char_i;
                mem[wr_ptr].ovf <= 1'b0;
                wr_ptr          <= nxt(wr_ptr);
            end
            if (drop && !imm_i)
                mem[last_ptr].ovf <= 1'b1;
            if (pop)
                rd_ptr <= nxt(rd_ptr);
            case ({push_ok, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
            if (pop)
                imm_q <= 1'b0;
            else if (drop && imm_i)
                imm_q <= 1'b1;
        end
    end

    // R10
    fill_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !rd_ack) |=> valid_o);

    // R11
    drop_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !rd_ack) |=> (full && $stable(wr_ptr)));

    // R12
    imm_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (drop && imm_i) |=> ovf_o);

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uos_pkg::*;
#(
    parameter int BUF_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             os_tick,
    input  logic             rxd,
    input  logic [2:0]       rate_sel,
    input  logic [1:0]       adj_sel,
    input  logic             rx_inv,
    input  logic             lsb_first,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             imm_ovf,
    input  logic             rd_ack,
    output logic [DBITS-1:0] rx_data,
    output logic             rx_valid,
    output logic             rx_perr,
    output logic             rx_ferr,
    output logic             rx_ovf
);

    logic     busy;
    logic     begin_w;
    logic     bit_done;
    logic     bit_val;
    logic     push;
    rx_char_t new_char;
    rx_char_t head;

    uos_bitclk u_bitclk (
        .clk        (clk),
        .rst        (rst),
        .tick       (os_tick),
        .rxd        (rxd),
        .rate       (rate_sel),
        .adj        (adj_sel),
        .busy       (busy),
        .begin_o    (begin_w),
        .bit_done_o (bit_done),
        .bit_val_o  (bit_val)
    );

    uos_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .begin_i   (begin_w),
        .bit_done  (bit_done),
        .bit_val   (bit_val),
        .rx_inv    (rx_inv),
        .lsb_first (lsb_first),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .busy      (busy),
        .push_o    (push),
        .char_o    (new_char)
    );

    uos_rxbuf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .char_i  (new_char),
        .rd_ack  (rd_ack),
        .imm_i   (imm_ovf),
        .head_o  (head),
        .valid_o (rx_valid),
        .ovf_o   (rx_ovf)
    );

    assign rx_data = head.data;
    assign rx_perr = head.perr;
    assign rx_ferr = head.ferr;

    // R14
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!rx_valid && !rx_ovf));

endmodule

// File: tb/sim_uart_os_rx.sv
module sim_uart_os_rx;

    typedef struct packed {
        logic [2:0] rate;
        logic [1:0] adj;
        logic       inv;
        logic       lsb;
        logic       pen;
        logic       podd;
        logic       glitch;
        logic       bpar;
        logic       bstop;
        logic [7:0] d;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
        '{3'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C},
        '{3'd0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81},
        '{3'd2, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5A},
        '{3'd3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF0},
        '{3'd2, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC3},
        '{3'd4, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h96},
        '{3'd4, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h7E},
        '{3'd5, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11},
        '{3'd0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hE7},
        '{3'd2, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [2:0] rate_sel = 3'd0;
    logic [1:0] adj_sel = 2'd0;
    logic       rx_inv = 1'b0;
    logic       lsb_first = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       imm_ovf = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_perr;
    logic       rx_ferr;
    logic       rx_ovf;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    uart_os_rx u0 (
        .clk (clk), .rst (rst), .os_tick (os_tick), .rxd (rxd),
        .rate_sel (rate_sel), .adj_sel (adj_sel), .rx_inv (rx_inv),
        .lsb_first (lsb_first), .par_en (par_en), .par_odd (par_odd),
        .imm_ovf (imm_ovf), .rd_ack (rd_ack), .rx_data (rx_data),
        .rx_valid (rx_valid), .rx_perr (rx_perr), .rx_ferr (rx_ferr),
        .rx_ovf (rx_ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int olen(input logic [2:0] r);
        if (r == 3'd2 || r == 3'd3) return 8;
        if (r == 3'd4) return 3;
        return 16;
    endfunction

    function automatic int wlo(input logic [2:0] r, input logic [1:0] a);
        if (r == 3'd2 || r == 3'd3) return 3 + int'(a);
        if (r == 3'd4) return 1;
        return 7 + 2 * int'(a);
    endfunction

    task automatic one_tick(input logic lvl);
        @(negedge clk);
        os_tick = 1'b1;
        rxd     = lvl;
        @(negedge clk);
        os_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // masked bits carry the true level only inside the sample window
    task automatic send_bit(input int n, input int lo, input logic v,
                            input bit masked, input bit glitch);
        for (int p = 1; p <= n; p++) begin
            logic lvl;
            if (!masked)
                lvl = v;
            else if (p >= lo && p <= lo + 2)
                lvl = (glitch && p == lo + 1) ? ~v : v;
            else
                lvl = ~v;
            one_tick(lvl);
        end
    endtask

    task automatic idle_ticks(input int k);
        for (int i = 0; i < k; i++) one_tick(1'b1);
    endtask

    task automatic send_frame(input vec_t v);
        int n;
        int lo;
        logic [7:0] line;
        @(negedge clk);
        rate_sel  = v.rate;
        adj_sel   = v.adj;
        rx_inv    = v.inv;
        lsb_first = v.lsb;
        par_en    = v.pen;
        par_odd   = v.podd;
        n    = olen(v.rate);
        lo   = wlo(v.rate, v.adj);
        line = v.d ^ {8{v.inv}};
        idle_ticks(2);
        send_bit(n, lo, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++)
            send_bit(n, lo, v.lsb ? line[i] : line[7-i], 1'b1, v.glitch);
        if (v.pen)
            send_bit(n, lo, (^v.d) ^ v.podd ^ v.bpar, 1'b1, v.glitch);
        send_bit(n, lo, ~v.bstop, 1'b0, 1'b0);
        idle_ticks(2);
    endtask

    task automatic pop();
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    function automatic vec_t plain(input logic [7:0] d);
        vec_t t;
        t      = '0;
        t.rate = 3'd2;
        t.d    = d;
        return t;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R14 valid after reset", 32'(rx_valid), 32'd0);
        chk("R14 ovf after reset", 32'(rx_ovf), 32'd0);

        // table walk: each entry is one character, read back and removed
        for (int i = 0; i < NV; i++) begin
            send_frame(VECS[i]);
            chk("R10 valid after frame", 32'(rx_valid), 32'd1);
            chk("R1/R2/R3/R4/R6/R7 data", 32'(rx_data), 32'(VECS[i].d));
            chk("R8/R7 parity error", 32'(rx_perr), 32'(VECS[i].pen & VECS[i].bpar));
            chk("R9 frame error", 32'(rx_ferr), 32'(VECS[i].bstop));
            pop();
            chk("R10 empty after read", 32'(rx_valid), 32'd0);
        end

        // R5: low only on the first tick, majority high -> no character
        @(negedge clk);
        rate_sel = 3'd0;
        adj_sel  = 2'd0;
        idle_ticks(2);
        one_tick(1'b0);
        for (int p = 2; p <= 16; p++) one_tick(1'b1);
        idle_ticks(4);
        chk("R5 false start stores nothing", 32'(rx_valid), 32'd0);
        send_frame(plain(8'h6D));
        chk("R5 frame after false start", 32'(rx_data), 32'h6D);
        pop();

        // R11/R12 immediate overflow
        imm_ovf = 1'b1;
        send_frame(plain(8'h12));
        send_frame(plain(8'h34));
        chk("R12 no ovf while not full", 32'(rx_ovf), 32'd0);
        send_frame(plain(8'h56));
        chk("R12 ovf raised at once", 32'(rx_ovf), 32'd1);
        chk("R10 oldest at head", 32'(rx_data), 32'h12);
        pop();
        chk("R12 ovf cleared by read", 32'(rx_ovf), 32'd0);
        chk("R11 second kept", 32'(rx_data), 32'h34);
        pop();
        chk("R11 third dropped", 32'(rx_valid), 32'd0);

        // R13 stream-order overflow
        imm_ovf = 1'b0;
        send_frame(plain(8'h9A));
        send_frame(plain(8'hBC));
        send_frame(plain(8'hDE));
        chk("R13 no ovf at first entry", 32'(rx_ovf), 32'd0);
        chk("R13 first entry data", 32'(rx_data), 32'h9A);
        pop();
        chk("R13 ovf with newest entry", 32'(rx_ovf), 32'd1);
        chk("R13 newest entry data", 32'(rx_data), 32'hBC);
        pop();
        chk("R13 ovf gone when empty", 32'(rx_ovf), 32'd0);
        chk("R11 dropped entry absent", 32'(rx_valid), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule